// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Line-Driver Enable and Flow Control

This block is a full-duplex asynchronous serial port. Transmit and receive timing come from an external oversampling tick, and each bit lasts `OVS` ticks. The transmitter serialises bytes taken from a valid/ready stream. The receiver recovers frames from the serial input and presents them on a second valid/ready stream, together with parity and framing error flags.

The frame format is set at run time through a 7-bit configuration word. It selects the word length, the stop length, one of five parity treatments and one of three flow-control modes. The transmitter also drives an enable output for a half-duplex RS485 line driver. This output turns on one bit time before the start bit and turns off as soon as the last stop bit has gone out. Hardware handshaking uses an RTS/CTS pair. Software handshaking reacts to in-band pause and resume characters that arrive on the receive line.

Top module: `sercom_uart`

## Requirements
- R1: Configuration word bit 0 selects the word length (0 = 8 bits, 1 = 7 bits). Data goes out least significant bit first after a low start bit. With 7 bits, bit 7 of the transmit byte is not sent.
- R2: Configuration bits [4:2] select the parity bit, which follows the data: 0 none, 1 odd (total count of ones odd), 2 even, 3 mark (always 1), 4 space (always 0).
- R3: Configuration bit 1 selects the stop length (0 = one high stop bit, 1 = two).
- R4: `drv_en` rises when a byte is accepted, between 15 and 16 bit-tick periods before the start bit. It stays high through every bit of the frame and falls when the final stop bit ends. `txd` is never low while `drv_en` is low.
- R5: When configuration bits [6:5] = 1 (hardware handshake), `tx_ready` is low and no frame starts while `cts` is low, and `rts` equals `rx_ready`. In the other modes `rts` is high.
- R6: When bits [6:5] = 2 (software handshake), a received 0x13 stops new transmissions from starting, and any frame already in progress finishes intact. A received 0x11 lets them start again. Neither character appears on the receive stream.
- R7: The receiver accepts a start bit only if the input is still low half a bit after the falling edge. A shorter low pulse produces no output. Each later bit is sampled at its middle.
- R8: `rx_perr` is set with the delivered byte when the received parity bit differs from the value the selected mode requires.
- R9: `rx_ferr` is set with the delivered byte when the first stop bit samples low.
- R10: A delivered byte stays on `rx_data` with `rx_valid` high until `rx_ready` is high. With 7-bit words, `rx_data[7]` is 0.
- R11: After reset `txd` is high, `drv_en` and `rx_valid` are low, and `tx_ready` is high in the no-flow-control mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling tick, one clock wide |
| cfg_word | input | 7 | Frame format and flow-control selection |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error for the held byte |
| rx_ferr | output | 1 | Framing error for the held byte |
| rx_valid | output | 1 | Received byte is held |
| rx_ready | input | 1 | Sink takes the held byte |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rts | output | 1 | High when the local sink can take data |
| cts | input | 1 | High when the far end permits sending |
| drv_en | output | 1 | Line-driver enable for RS485 |

## Verification
The receiver can take in a pause character while the transmitter is in the middle of a frame. The receive side then changes the transmit permission while a character is still going out. The bench provokes this under software handshaking. It starts a long transmit frame (8 data bits, parity, two stop bits), and while it runs, it drives a 0x13 frame onto the receive line so that the pause lands during the transmit stop bits. It then checks that every transmitted bit still matches the expected frame, that the enable output falls on time, that `tx_ready` stays low afterwards with nothing delivered on the receive stream, and that a later 0x11 raises `tx_ready` again.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_e;

    typedef enum logic [1:0] {
        FLOW_NONE = 2'd0,
        FLOW_HW   = 2'd1,
        FLOW_SW   = 2'd2
    } flow_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_st_e;

    localparam logic [7:0] PAUSE_CHAR  = 8'h13;
    localparam logic [7:0] RESUME_CHAR = 8'h11;

    // Parity bit required for an already masked data word
    function automatic logic par_bit(input par_e mode, input logic [7:0] word);
        case (mode)
            PAR_ODD:  return ~(^word);
            PAR_EVEN: return ^word;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sercom_tx.sv
module sercom_tx
    import sercom_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cfg_data7,
    input  logic       cfg_stop2,
    input  par_e       cfg_par,
    input  logic       go_ok,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    output logic       drv_en
);

    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] TCNT_LAST = CW'(OVS - 1);

    typedef struct packed {
        tx_st_e        st;
        logic [CW-1:0] tcnt;
        logic [2:0]    bidx;
        logic [7:0]    shreg;
        logic          pbit;
        logic          sidx;
        logic          data7;
        logic          stop2;
        par_e          par;
        logic          txd;
        logic          den;
    } tx_q_t;

    localparam tx_q_t TX_RST = '{
        st: TX_IDLE, tcnt: '0, bidx: '0, shreg: '0, pbit: 1'b0, sidx: 1'b0,
        data7: 1'b0, stop2: 1'b0, par: PAR_NONE, txd: 1'b1, den: 1'b0
    };

    tx_q_t tx_q, tx_d;
    logic [2:0] last_bit;

    assign last_bit = tx_q.data7 ? 3'd6 : 3'd7;
    assign tx_ready = (tx_q.st == TX_IDLE) && go_ok;
    assign txd      = tx_q.txd;
    assign drv_en   = tx_q.den;

    always_comb begin
        tx_d = tx_q;
        case (tx_q.st)
            TX_IDLE: begin
                tx_d.txd = 1'b1;
                tx_d.den = 1'b0;
                if (tx_valid && go_ok) begin
                    tx_d.st    = TX_LEAD;
                    tx_d.tcnt  = '0;
                    tx_d.data7 = cfg_data7;
                    tx_d.stop2 = cfg_stop2;
                    tx_d.par   = cfg_par;
                    tx_d.shreg = cfg_data7 ? {1'b0, tx_data[6:0]} : tx_data;
                    tx_d.pbit  = par_bit(cfg_par,
                                         cfg_data7 ? {1'b0, tx_data[6:0]} : tx_data);
                    tx_d.den   = 1'b1;
                end
            end
            default: begin
                if (tick) begin
                    if (tx_q.tcnt != TCNT_LAST) begin
                        tx_d.tcnt = tx_q.tcnt + 1'b1;
                    end else begin
                        tx_d.tcnt = '0;
                        case (tx_q.st)
                            TX_LEAD: begin
                                tx_d.st  = TX_START;
                                tx_d.txd = 1'b0;
                            end
                            TX_START: begin
                                tx_d.st   = TX_DATA;
                                tx_d.bidx = '0;
                                tx_d.txd  = tx_q.shreg[0];
                            end
                            TX_DATA: begin
                                if (tx_q.bidx == last_bit) begin
                                    if (tx_q.par != PAR_NONE) begin
                                        tx_d.st  = TX_PAR;
                                        tx_d.txd = tx_q.pbit;
                                    end else begin
                                        tx_d.st   = TX_STOP;
                                        tx_d.sidx = 1'b0;
                                        tx_d.txd  = 1'b1;
                                    end
                                end else begin
                                    tx_d.bidx  = tx_q.bidx + 3'd1;
                                    tx_d.shreg = {1'b0, tx_q.shreg[7:1]};
                                    tx_d.txd   = tx_q.shreg[1];
                                end
                            end
                            TX_PAR: begin
                                tx_d.st   = TX_STOP;
                                tx_d.sidx = 1'b0;
                                tx_d.txd  = 1'b1;
                            end
                            TX_STOP: begin
                                if (tx_q.stop2 && !tx_q.sidx) begin
                                    tx_d.sidx = 1'b1;
                                end else begin
                                    tx_d.st  = TX_IDLE;
                                    tx_d.den = 1'b0;
                                end
                            end
                            default: tx_d.st = TX_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= TX_RST;
        else        tx_q <= tx_d;
    end

    AST_LOW_NEEDS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> drv_en); // R4
    AST_DRIVER_LEADS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(drv_en)); // R4
    AST_START_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> $past(go_ok && tx_valid)); // R5

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cfg_data7,
    input  par_e       cfg_par,
    input  logic       sw_flow,
    input  logic       rxd,
    input  logic       rx_ready,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       paused
);

    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] TCNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] TCNT_HALF = CW'((OVS / 2) - 1);

    typedef struct packed {
        logic [1:0]    sync;
        rx_st_e        st;
        logic [CW-1:0] tcnt;
        logic [2:0]    bidx;
        logic [7:0]    shreg;
        logic          pbit;
        logic          data7;
        par_e          par;
        logic [7:0]    data;
        logic          valid;
        logic          perr;
        logic          ferr;
        logic          paused;
    } rx_q_t;

    localparam rx_q_t RX_RST = '{
        sync: 2'b11, st: RX_IDLE, tcnt: '0, bidx: '0, shreg: '0, pbit: 1'b0,
        data7: 1'b0, par: PAR_NONE, data: '0, valid: 1'b0, perr: 1'b0,
        ferr: 1'b0, paused: 1'b0
    };

    rx_q_t rx_q, rx_d;
    logic       line;
    logic [7:0] word;
    logic       bad_par;

    assign line     = rx_q.sync[1];
    assign word     = rx_q.data7 ? {1'b0, rx_q.shreg[7:1]} : rx_q.shreg;
    assign bad_par  = (rx_q.par != PAR_NONE) && (rx_q.pbit != par_bit(rx_q.par, word));
    assign rx_data  = rx_q.data;
    assign rx_valid = rx_q.valid;
    assign rx_perr  = rx_q.perr;
    assign rx_ferr  = rx_q.ferr;
    assign paused   = rx_q.paused;

    always_comb begin
        rx_d      = rx_q;
        rx_d.sync = {rx_q.sync[0], rxd};
        if (rx_q.valid && rx_ready) rx_d.valid = 1'b0;
        if (!sw_flow) rx_d.paused = 1'b0;
        case (rx_q.st)
            RX_IDLE: begin
                if (tick && !line) begin
                    rx_d.st    = RX_START;
                    rx_d.tcnt  = '0;
                    rx_d.data7 = cfg_data7;
                    rx_d.par   = cfg_par;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (rx_q.tcnt == TCNT_HALF) begin
                        rx_d.tcnt = '0;
                        rx_d.bidx = '0;
                        rx_d.st   = line ? RX_IDLE : RX_DATA;
                    end else begin
                        rx_d.tcnt = rx_q.tcnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (rx_q.tcnt != TCNT_LAST) begin
                        rx_d.tcnt = rx_q.tcnt + 1'b1;
                    end else begin
                        rx_d.tcnt = '0;
                        case (rx_q.st)
                            RX_DATA: begin
                                rx_d.shreg = {line, rx_q.shreg[7:1]};
                                if (rx_q.bidx == (rx_q.data7 ? 3'd6 : 3'd7))
                                    rx_d.st = (rx_q.par != PAR_NONE) ? RX_PAR : RX_STOP;
                                else
                                    rx_d.bidx = rx_q.bidx + 3'd1;
                            end
                            RX_PAR: begin
                                rx_d.pbit = line;
                                rx_d.st   = RX_STOP;
                            end
                            RX_STOP: begin
                                rx_d.st = RX_IDLE;
                                if (sw_flow && !bad_par && line && word == PAUSE_CHAR) begin
                                    rx_d.paused = 1'b1;
                                end else if (sw_flow && !bad_par && line && word == RESUME_CHAR) begin
                                    rx_d.paused = 1'b0;
                                end else begin
                                    rx_d.data  = word;
                                    rx_d.valid = 1'b1;
                                    rx_d.perr  = bad_par;
                                    rx_d.ferr  = !line;
                                end
                            end
                            default: rx_d.st = RX_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= RX_RST;
        else        rx_q <= rx_d;
    end

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R10
    AST_SHORT_WORD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) && rx_q.data7 |-> !rx_data[7]); // R10
    AST_NO_PAUSE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) && sw_flow |-> !(rx_data == PAUSE_CHAR && !rx_perr && !rx_ferr)); // R6

endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
    import sercom_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [6:0] cfg_word,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_valid,
    input  logic       rx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic       rts,
    input  logic       cts,
    output logic       drv_en
);

    logic  cfg_data7;
    logic  cfg_stop2;
    par_e  cfg_par;
    flow_e cfg_flow;
    logic  paused;
    logic  go_ok;

    assign cfg_data7 = cfg_word[0];
    assign cfg_stop2 = cfg_word[1];
    assign cfg_par   = par_e'(cfg_word[4:2]);
    assign cfg_flow  = flow_e'(cfg_word[6:5]);

    always_comb begin
        case (cfg_flow)
            FLOW_HW: begin go_ok = cts;     rts = rx_ready; end
            FLOW_SW: begin go_ok = !paused; rts = 1'b1;     end
            default: begin go_ok = 1'b1;    rts = 1'b1;     end
        endcase
    end

    sercom_tx #(.OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cfg_data7(cfg_data7),
        .cfg_stop2(cfg_stop2),
        .cfg_par  (cfg_par),
        .go_ok    (go_ok),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd),
        .drv_en   (drv_en)
    );

    sercom_rx #(.OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cfg_data7(cfg_data7),
        .cfg_par  (cfg_par),
        .sw_flow  (cfg_flow == FLOW_SW),
        .rxd      (rxd),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr),
        .paused   (paused)
    );

    AST_PAUSE_BLOCKS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow == FLOW_SW) && paused |-> !tx_ready); // R6
    AST_CTS_BLOCKS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow == FLOW_HW) && !cts |-> !tx_ready); // R5

endmodule

// File: tb/sercom_uart_bench.sv
module sercom_uart_bench;

    localparam int BIT = 64; // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [6:0] cfg_word;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_valid, rx_ready;
    logic       txd, rxd, rts, cts, drv_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sercom_uart #(.OVS(16)) u_sercom_uart (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_word(cfg_word),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .txd(txd), .rxd(rxd),
        .rts(rts), .cts(cts), .drv_en(drv_en)
    );

    initial begin
        tick = 1'b0;
        forever begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                tick = (k == 3);
            end
        end
    end

    function automatic logic [6:0] mkcfg(input bit d7, input bit s2,
                                         input logic [2:0] par, input logic [1:0] flow);
        return {flow, par, s2, d7};
    endfunction

    function automatic bit exp_par(input logic [2:0] p, input logic [7:0] m);
        case (p)
            3'd1: return ~(^m);
            3'd2: return ^m;
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tx_frame(input logic [7:0] b, input bit d7, input logic [2:0] par,
                            input bit s2, input string req);
        logic [12:0] bits;
        logic [7:0]  m;
        int nb;
        int lead;
        m = d7 ? {1'b0, b[6:0]} : b;
        bits = '0;
        nb = 1;
        for (int i = 0; i < (d7 ? 7 : 8); i++) begin bits[nb] = m[i]; nb++; end
        if (par != 3'd0) begin bits[nb] = exp_par(par, m); nb++; end
        bits[nb] = 1'b1; nb++;
        if (s2) begin bits[nb] = 1'b1; nb++; end
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(drv_en == 1'b1, "R4 enable on accept", {31'd0, drv_en}, 32'd1);
        lead = 1;
        while (txd) begin @(negedge clk); lead++; end
        chk(lead >= 60 && lead <= 64, "R4 lead time", lead, 64);
        repeat (31) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            chk(txd == bits[i] && drv_en, req, {30'd0, txd, drv_en}, {30'd0, bits[i], 1'b1});
            if (i < nb - 1) repeat (BIT) @(negedge clk);
        end
        repeat (34) @(negedge clk);
        chk(!drv_en && txd, "R4 release after stop", {30'd0, txd, drv_en}, 32'd2);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit d7, input bit pen,
                           input bit pval, input bit stopv, input bit s2);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < (d7 ? 7 : 8); i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        if (pen) begin rxd = pval; repeat (BIT) @(negedge clk); end
        rxd = stopv;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        if (s2) repeat (BIT) @(negedge clk);
    endtask

    task automatic rx_take(input logic [7:0] ed, input bit ep, input bit ef,
                           input string req);
        repeat (50) @(negedge clk);
        chk(rx_valid == 1'b1, "R10 held valid", {31'd0, rx_valid}, 32'd1);
        chk(rx_data == ed, req, rx_data, ed);
        chk(rx_perr == ep, "R8 parity flag", {31'd0, rx_perr}, {31'd0, ep});
        chk(rx_ferr == ef, "R9 framing flag", {31'd0, rx_ferr}, {31'd0, ef});
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        @(negedge clk);
        chk(rx_valid == 1'b0, "R10 taken", {31'd0, rx_valid}, 32'd0);
    endtask

    task automatic t_reset;
        chk(txd == 1'b1, "R11 txd idle", {31'd0, txd}, 32'd1);
        chk(drv_en == 1'b0, "R11 driver off", {31'd0, drv_en}, 32'd0);
        chk(rx_valid == 1'b0, "R11 no rx", {31'd0, rx_valid}, 32'd0);
        chk(tx_ready == 1'b1, "R11 ready", {31'd0, tx_ready}, 32'd1);
    endtask

    task automatic t_tx_formats;
        cfg_word = mkcfg(0, 0, 3'd0, 2'd0);
        tx_frame(8'hA5, 0, 3'd0, 0, "R1 8N1 A5");
        tx_frame(8'h3C, 0, 3'd0, 0, "R1 8N1 3C");
        cfg_word = mkcfg(1, 1, 3'd2, 2'd0);
        tx_frame(8'hC3, 1, 3'd2, 1, "R3 7E2 bit7 dropped");
        cfg_word = mkcfg(0, 0, 3'd1, 2'd0);
        tx_frame(8'h0F, 0, 3'd1, 0, "R2 odd");
        cfg_word = mkcfg(0, 0, 3'd3, 2'd0);
        tx_frame(8'h00, 0, 3'd3, 0, "R2 mark");
        cfg_word = mkcfg(1, 0, 3'd4, 2'd0);
        tx_frame(8'hFF, 1, 3'd4, 0, "R2 space");
    endtask

    task automatic t_rx_formats;
        cfg_word = mkcfg(0, 0, 3'd0, 2'd0);
        send_rx(8'h3C, 0, 0, 0, 1, 0);
        rx_take(8'h3C, 0, 0, "R7 rx 8N1");
        cfg_word = mkcfg(1, 0, 3'd2, 2'd0);
        send_rx(8'h7F, 1, 1, exp_par(3'd2, 8'h7F), 1, 0);
        rx_take(8'h7F, 0, 0, "R10 rx 7-bit msb zero");
    endtask

    task automatic t_rx_errors;
        cfg_word = mkcfg(0, 0, 3'd2, 2'd0);
        send_rx(8'h01, 0, 1, 1'b0, 1, 0);
        rx_take(8'h01, 1, 0, "R8 bad parity data");
        cfg_word = mkcfg(0, 0, 3'd0, 2'd0);
        send_rx(8'h96, 0, 0, 0, 0, 0);
        rx_take(8'h96, 0, 1, "R9 low stop data");
        repeat (200) @(negedge clk);
        chk(rx_valid == 1'b0, "R9 no spurious byte", {31'd0, rx_valid}, 32'd0);
    endtask

    task automatic t_false_start;
        cfg_word = mkcfg(0, 0, 3'd0, 2'd0);
        @(negedge clk);
        rxd = 1'b0;
        repeat (10) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk(rx_valid == 1'b0, "R7 glitch rejected", {31'd0, rx_valid}, 32'd0);
        send_rx(8'h5B, 0, 0, 0, 1, 0);
        rx_take(8'h5B, 0, 0, "R7 recovery after glitch");
    endtask

    task automatic t_hw_flow;
        cfg_word = mkcfg(0, 0, 3'd0, 2'd1);
        cts = 1'b0;
        rx_ready = 1'b0;
        @(negedge clk);
        chk(rts == 1'b0, "R5 rts follows sink", {31'd0, rts}, 32'd0);
        rx_ready = 1'b1;
        @(negedge clk);
        chk(rts == 1'b1, "R5 rts follows sink", {31'd0, rts}, 32'd1);
        rx_ready = 1'b0;
        chk(tx_ready == 1'b0, "R5 cts low blocks", {31'd0, tx_ready}, 32'd0);
        tx_data = 8'h81;
        tx_valid = 1'b1;
        repeat (300) @(negedge clk);
        chk(!drv_en && txd, "R5 no frame while cts low", {30'd0, txd, drv_en}, 32'd2);
        tx_valid = 1'b0;
        cts = 1'b1;
        tx_frame(8'h81, 0, 3'd0, 0, "R5 sends after cts");
        cfg_word = mkcfg(0, 0, 3'd0, 2'd0);
        @(negedge clk);
        chk(rts == 1'b1, "R5 rts high without handshake", {31'd0, rts}, 32'd1);
    endtask

    task automatic t_sw_flow;
        cfg_word = mkcfg(0, 0, 3'd0, 2'd2);
        send_rx(8'h13, 0, 0, 0, 1, 0);
        repeat (20) @(negedge clk);
        chk(rx_valid == 1'b0, "R6 pause not forwarded", {31'd0, rx_valid}, 32'd0);
        chk(tx_ready == 1'b0, "R6 paused", {31'd0, tx_ready}, 32'd0);
        send_rx(8'h11, 0, 0, 0, 1, 0);
        repeat (20) @(negedge clk);
        chk(rx_valid == 1'b0, "R6 resume not forwarded", {31'd0, rx_valid}, 32'd0);
        chk(tx_ready == 1'b1, "R6 resumed", {31'd0, tx_ready}, 32'd1);
        send_rx(8'h41, 0, 0, 0, 1, 0);
        rx_take(8'h41, 0, 0, "R6 ordinary byte passes");
    endtask

    task automatic t_pause_mid_frame;
        cfg_word = mkcfg(0, 1, 3'd2, 2'd2);
        fork
            tx_frame(8'h5A, 0, 3'd2, 1, "R6 frame intact under pause");
            begin
                repeat (50) @(negedge clk);
                send_rx(8'h13, 0, 1, exp_par(3'd2, 8'h13), 1, 1);
            end
        join
        repeat (20) @(negedge clk);
        chk(tx_ready == 1'b0, "R6 paused after frame", {31'd0, tx_ready}, 32'd0);
        chk(rx_valid == 1'b0, "R6 pause not forwarded", {31'd0, rx_valid}, 32'd0);
        send_rx(8'h11, 0, 1, exp_par(3'd2, 8'h11), 1, 1);
        repeat (20) @(negedge clk);
        chk(tx_ready == 1'b1, "R6 resumed", {31'd0, tx_ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        cfg_word = '0;
        tx_data  = '0;
        tx_valid = 1'b0;
        rx_ready = 1'b0;
        rxd      = 1'b1;
        cts      = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_formats();
        t_rx_formats();
        t_rx_errors();
        t_false_start();
        t_hw_flow();
        t_sw_flow();
        t_pause_mid_frame();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule